// File: doc/BRIEF.md
# Paper Tape Reader and Punch Controller

This block sits on a simple register bus and runs two character devices: a tape reader that delivers bytes and a tape punch that accepts them. Software sees four 16-bit word registers, a status word and a data buffer for each device. The reader side starts a fetch when software sets the start bit. The punch side starts a cycle when software writes a byte. Each side reports completion, faults and interrupt state through its own status word and raises its own interrupt request line.

Toward the mechanisms, each side has a level request and a one-cycle completion strobe. The reader side also takes a byte input, and the punch side drives a byte output. A media-present input on each side decides whether a completed cycle counts as a success or as an error. Mechanism timing lives outside the block, and the completion strobe marks the end of a cycle. Interrupt priority among devices is also outside the block.

Top module: `ptape_ctrl`

## Requirements
- R1: Bus address bits [2:1] select the register: 0 reader status, 1 reader buffer, 2 punch status, 3 punch buffer. In a status word, bit 15 is the error flag (ERR), bit 11 is the reader's busy flag (BUSY), bit 7 is the done flag (DONE) and bit 6 is the interrupt enable (IE). Every other bit reads as 0, and the punch status has no busy bit. A buffer reads back with its byte in bits [7:0] and zeros above.
- R2: In either status word, only bit 6 (IE) can be written. Writes to ERR, DONE or BUSY leave those flags unchanged.
- R3: A status write with IE=0 clears that side's interrupt request. A status write with IE=1, when IE was 0 and ERR or DONE is set, raises the request. An interrupt request is never set while IE is clear.
- R4: A byte write (bus_byte=1) to the odd address of a status register changes nothing.
- R5: A reader status write with bit 0 (start) set clears DONE, sets BUSY, clears the reader interrupt and asserts the reader request until completion.
- R6: A reader completion strobe while BUSY clears BUSY. If media is present, it also latches the input byte, sets DONE and clears ERR. If media is absent, it sets ERR and leaves the buffer unchanged. In both cases it raises the interrupt if IE is set.
- R7: A read of the reader buffer returns the latched byte, then clears DONE and the reader interrupt.
- R8: Any write to the punch buffer clears DONE and the punch interrupt and starts a punch cycle (request high). It loads bits [7:0] only when the access is at the even address, and the punch buffer reads back and drives the last byte loaded.
- R9: A punch completion strobe during a cycle ends the request and sets DONE. It sets ERR exactly when media is absent and raises the interrupt if IE is set.
- R10: After reset, the reader status is 0 and the punch status is DONE. Each side's ERR equals the inverse of its media-present input. The buffers are 0 and both interrupt requests are low.
- R11: A completion strobe with no cycle in progress on that side has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address within the block |
| bus_byte | input | 1 | Access is a single byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| rdr_media | input | 1 | Reader media present |
| rdr_req | output | 1 | Reader fetch in progress |
| rdr_stb | input | 1 | Reader completion strobe |
| rdr_byte | input | 8 | Byte from the reader mechanism |
| rdr_irq | output | 1 | Reader interrupt request |
| pch_media | input | 1 | Punch media present |
| pch_req | output | 1 | Punch cycle in progress |
| pch_stb | input | 1 | Punch completion strobe |
| pch_byte | output | 8 | Byte presented to the punch |
| pch_irq | output | 1 | Punch interrupt request |

## Verification
Read data is combinational, so a read shows the state before its clock edge. The side effects of a buffer read take hold at that edge. Every write, start and completion strobe becomes visible on status, request and interrupt outputs exactly one edge later. The bench applies each stimulus for one cycle starting at a falling edge and samples shortly after the next falling edge, which is the first point where the result is due. Reads capture data inside the same cycle, before the edge that applies their side effect.

// File: rtl/ptape_pkg.sv
package ptape_pkg;
    localparam int WORD_W   = 16;
    localparam int CHAR_W   = 8;
    localparam int BIT_ERR  = 15;
    localparam int BIT_BUSY = 11;
    localparam int BIT_DONE = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_GO   = 0;

    typedef enum logic [1:0] {
        SEL_RSTAT = 2'd0,
        SEL_RDATA = 2'd1,
        SEL_PSTAT = 2'd2,
        SEL_PDATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              err;
        logic              busy;
        logic              done;
        logic              ie;
        logic              irq;
        logic [CHAR_W-1:0] data;
    } rdr_state_t;

    typedef struct packed {
        logic              err;
        logic              active;
        logic              done;
        logic              ie;
        logic              irq;
        logic [CHAR_W-1:0] data;
    } pch_state_t;
endpackage

// File: rtl/ptape_rdr.sv
module ptape_rdr
    import ptape_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              media,
    input  logic              stat_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              data_rd,
    input  logic              done_stb,
    input  logic [CHAR_W-1:0] in_byte,
    output logic [WORD_W-1:0] stat_val,
    output logic [CHAR_W-1:0] data_val,
    output logic              req,
    output logic              irq
);
    rdr_state_t q, d;

    always_comb begin
        d = q;
        if (stat_wr) begin
            if (!wdata[BIT_IE])
                d.irq = 1'b0;
            else if (!q.ie && (q.err || q.done))
                d.irq = 1'b1;
            if (wdata[BIT_GO]) begin
                d.done = 1'b0;
                d.busy = 1'b1;
                d.irq  = 1'b0;
            end
            d.ie = wdata[BIT_IE];
        end
        if (data_rd) begin
            d.done = 1'b0;
            d.irq  = 1'b0;
        end
        if (q.busy && done_stb) begin
            d.busy = 1'b0;
            if (media) begin
                d.data = in_byte;
                d.done = 1'b1;
                d.err  = 1'b0;
            end else begin
                d.err = 1'b1;
            end
            if (d.ie)
                d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.err <= ~media;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        stat_val           = '0;
        stat_val[BIT_ERR]  = q.err;
        stat_val[BIT_BUSY] = q.busy;
        stat_val[BIT_DONE] = q.done;
        stat_val[BIT_IE]   = q.ie;
    end

    assign data_val = q.data;
    assign req      = q.busy;
    assign irq      = q.irq;

    assert_irq_needs_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> q.ie);
    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[BIT_GO] && !data_rd && !(q.busy && done_stb))
        |=> (req && !q.done && !irq));
    assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && done_stb && media && !stat_wr && !data_rd)
        |=> (q.done && !q.err && !req && data_val == $past(in_byte)));
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !stat_wr && !(q.busy && done_stb)) |=> (!q.done && !irq));
    assert_idle_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && done_stb && !stat_wr && !data_rd) |=> $stable(q));
endmodule

// File: rtl/ptape_pch.sv
module ptape_pch
    import ptape_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              media,
    input  logic              stat_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              data_wr,
    input  logic              data_load,
    input  logic              done_stb,
    output logic [WORD_W-1:0] stat_val,
    output logic [CHAR_W-1:0] data_val,
    output logic              req,
    output logic              irq
);
    pch_state_t q, d;

    always_comb begin
        d = q;
        if (stat_wr) begin
            if (!wdata[BIT_IE])
                d.irq = 1'b0;
            else if (!q.ie && (q.err || q.done))
                d.irq = 1'b1;
            d.ie = wdata[BIT_IE];
        end
        if (data_wr) begin
            if (data_load)
                d.data = wdata[CHAR_W-1:0];
            d.done   = 1'b0;
            d.irq    = 1'b0;
            d.active = 1'b1;
        end
        if (q.active && done_stb) begin
            d.active = 1'b0;
            d.done   = 1'b1;
            d.err    = ~media;
            if (d.ie)
                d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.done <= 1'b1;
            q.err  <= ~media;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        stat_val           = '0;
        stat_val[BIT_ERR]  = q.err;
        stat_val[BIT_DONE] = q.done;
        stat_val[BIT_IE]   = q.ie;
    end

    assign data_val = q.data;
    assign req      = q.active;
    assign irq      = q.irq;

    assert_punch_irq_needs_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> q.ie);
    assert_punch_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !(q.active && done_stb)) |=> (req && !q.done && !irq));
    assert_punch_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && done_stb && !data_wr && !stat_wr)
        |=> (q.done && !req && q.err == !$past(media)));
    assert_punch_idle_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.active && done_stb && !data_wr && !stat_wr) |=> $stable(q));
endmodule

// File: rtl/ptape_ctrl.sv
module ptape_ctrl
    import ptape_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic              bus_byte,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              rdr_media,
    output logic              rdr_req,
    input  logic              rdr_stb,
    input  logic [CHAR_W-1:0] rdr_byte,
    output logic              rdr_irq,
    input  logic              pch_media,
    output logic              pch_req,
    input  logic              pch_stb,
    output logic [CHAR_W-1:0] pch_byte,
    output logic              pch_irq
);
    reg_sel_e          sel;
    logic              odd, wr, rd, stat_ok;
    logic              rstat_wr, rdata_rd, pstat_wr, pdata_wr, pdata_load;
    logic [WORD_W-1:0] rstat_val, pstat_val;
    logic [CHAR_W-1:0] rdata_val;

    assign sel        = reg_sel_e'(bus_addr[2:1]);
    assign odd        = bus_addr[0];
    assign wr         = bus_en && bus_we;
    assign rd         = bus_en && !bus_we;
    assign stat_ok    = !(bus_byte && odd);
    assign rstat_wr   = wr && (sel == SEL_RSTAT) && stat_ok;
    assign rdata_rd   = rd && (sel == SEL_RDATA);
    assign pstat_wr   = wr && (sel == SEL_PSTAT) && stat_ok;
    assign pdata_wr   = wr && (sel == SEL_PDATA);
    assign pdata_load = pdata_wr && !odd;

    ptape_rdr u_rdr (
        .clk(clk), .rst_n(rst_n), .media(rdr_media),
        .stat_wr(rstat_wr), .wdata(bus_wdata), .data_rd(rdata_rd),
        .done_stb(rdr_stb), .in_byte(rdr_byte),
        .stat_val(rstat_val), .data_val(rdata_val),
        .req(rdr_req), .irq(rdr_irq)
    );

    ptape_pch u_pch (
        .clk(clk), .rst_n(rst_n), .media(pch_media),
        .stat_wr(pstat_wr), .wdata(bus_wdata), .data_wr(pdata_wr),
        .data_load(pdata_load), .done_stb(pch_stb),
        .stat_val(pstat_val), .data_val(pch_byte),
        .req(pch_req), .irq(pch_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RSTAT: bus_rdata = rstat_val;
            SEL_RDATA: bus_rdata[CHAR_W-1:0] = rdata_val;
            SEL_PSTAT: bus_rdata = pstat_val;
            SEL_PDATA: bus_rdata[CHAR_W-1:0] = pch_byte;
            default:   bus_rdata = '0;
        endcase
    end

    assert_odd_status_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_byte && odd && (sel == SEL_RSTAT) && !rdr_stb)
        |=> ($stable(rstat_val) && $stable(rdr_irq)));
endmodule

// File: tb/sim_ptape_ctrl.sv
module sim_ptape_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rdr_media = 1'b0, rdr_stb = 1'b0;
    logic [7:0]  rdr_byte = '0;
    logic        rdr_req, rdr_irq;
    logic        pch_media = 1'b1, pch_stb = 1'b0;
    logic        pch_req, pch_irq;
    logic [7:0]  pch_byte;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    ptape_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rdr_media(rdr_media), .rdr_req(rdr_req),
        .rdr_stb(rdr_stb), .rdr_byte(rdr_byte), .rdr_irq(rdr_irq),
        .pch_media(pch_media), .pch_req(pch_req), .pch_stb(pch_stb),
        .pch_byte(pch_byte), .pch_irq(pch_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        #1;
    endtask

    task automatic bwr(input logic [2:0] a, input logic [15:0] v, input logic byt);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v; bus_byte = byt;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
        #1;
    endtask

    task automatic brd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
        #1;
    endtask

    task automatic rstb(input logic [7:0] b);
        @(negedge clk); rdr_stb = 1'b1; rdr_byte = b;
        @(negedge clk); rdr_stb = 1'b0;
        #1;
    endtask

    task automatic pstb();
        @(negedge clk); pch_stb = 1'b1;
        @(negedge clk); pch_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rdr_media = 1'b0; pch_media = 1'b1;
        do_reset();
        brd(3'd0, v); chk("R10 reader status, no media", v, 16'h8000);
        brd(3'd4, v); chk("R10 punch status, media", v, 16'h0080);
        brd(3'd2, v); chk("R10 reader buffer", v, 16'h0000);
        brd(3'd6, v); chk("R10 punch buffer", v, 16'h0000);
        chk("R10 irqs low", {14'd0, rdr_irq, pch_irq}, 16'h0);
        rdr_media = 1'b1; pch_media = 1'b0;
        do_reset();
        brd(3'd0, v); chk("R10 reader status, media", v, 16'h0000);
        brd(3'd4, v); chk("R10 punch status, no media", v, 16'h8080);
    endtask

    task automatic t_ie();
        logic [15:0] v;
        rdr_media = 1'b0;
        do_reset();
        bwr(3'd0, 16'hFFFE, 1'b0);
        brd(3'd0, v); chk("R2 only IE writable", v, 16'h8040);
        chk("R3 IE rise with ERR raises irq", {15'd0, rdr_irq}, 16'h1);
        chk("R1 reader not busy", {15'd0, rdr_req}, 16'h0);
        bwr(3'd0, 16'h0000, 1'b0);
        chk("R3 IE=0 clears irq", {15'd0, rdr_irq}, 16'h0);
        bwr(3'd0, 16'h0041, 1'b1);
        chk("R4 even status byte write applies", {15'd0, rdr_req}, 16'h1);
        rstb(8'h00);
        bwr(3'd0, 16'h0000, 1'b0);
        bwr(3'd1, 16'h4141, 1'b1);
        brd(3'd0, v); chk("R4 odd status byte ignored", v, 16'h8000);
        chk("R4 odd byte no start", {14'd0, rdr_req, rdr_irq}, 16'h0);
    endtask

    task automatic t_read();
        logic [15:0] v;
        rdr_media = 1'b1;
        do_reset();
        bwr(3'd0, 16'h0041, 1'b0);
        brd(3'd0, v); chk("R5 start sets busy", v, 16'h0840);
        chk("R5 request high, irq low", {14'd0, rdr_req, rdr_irq}, 16'h2);
        rstb(8'hA5);
        brd(3'd0, v); chk("R6 completion with media", v, 16'h00C0);
        chk("R6 irq raised", {14'd0, rdr_req, rdr_irq}, 16'h1);
        brd(3'd2, v); chk("R7 buffer read value", v, 16'h00A5);
        brd(3'd0, v); chk("R7 read clears DONE", v, 16'h0040);
        chk("R7 read clears irq", {15'd0, rdr_irq}, 16'h0);
        rdr_media = 1'b0;
        bwr(3'd0, 16'h0041, 1'b0);
        rstb(8'h5A);
        brd(3'd0, v); chk("R6 completion without media", v, 16'h8040);
        chk("R6 irq on error", {15'd0, rdr_irq}, 16'h1);
        brd(3'd2, v); chk("R6 buffer kept on error", v, 16'h00A5);
        bwr(3'd0, 16'h0040, 1'b0);
        rstb(8'h33);
        brd(3'd2, v); chk("R11 idle strobe no latch", v, 16'h00A5);
        brd(3'd0, v); chk("R11 idle strobe status", v, 16'h8040);
    endtask

    task automatic t_punch();
        logic [15:0] v;
        pch_media = 1'b1;
        do_reset();
        bwr(3'd4, 16'h0040, 1'b0);
        chk("R3 punch IE with DONE raises irq", {15'd0, pch_irq}, 16'h1);
        bwr(3'd6, 16'h1234, 1'b0);
        brd(3'd4, v); chk("R8 buffer write clears DONE", v, 16'h0040);
        chk("R8 request high irq low", {14'd0, pch_req, pch_irq}, 16'h2);
        chk("R8 byte presented", {8'd0, pch_byte}, 16'h0034);
        pstb();
        brd(3'd4, v); chk("R9 completion with media", v, 16'h00C0);
        chk("R9 irq raised", {14'd0, pch_req, pch_irq}, 16'h1);
        brd(3'd6, v); chk("R8 buffer readback", v, 16'h0034);
        bwr(3'd7, 16'h0099, 1'b1);
        brd(3'd6, v); chk("R8 odd write no load", v, 16'h0034);
        chk("R8 odd write starts cycle", {14'd0, pch_req, pch_irq}, 16'h2);
        pch_media = 1'b0;
        pstb();
        brd(3'd4, v); chk("R9 completion without media", v, 16'h80C0);
        pstb();
        brd(3'd4, v); chk("R11 idle punch strobe", v, 16'h80C0);
    endtask

    initial begin
        t_reset();
        t_ie();
        t_read();
        t_punch();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule